// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit is the multiply-accumulate stage of a 32-bit processor's execute pipeline. Each accepted operation carries one register operand, one immediate operand and a 4-bit operation code. The unit multiplies the operands in one of ten modes and either folds the product into a 64-bit accumulator or, for the dual multiply modes, writes its two products out. The accumulator is kept as two 32-bit halves. There is also a sticky overflow flag that only software can clear.

Operations arrive on a valid/ready stream. The unit takes one operation per clock and never applies back-pressure, so `in_ready` stays high. An operation is accepted on a rising edge where `in_valid` is high, and its effect shows on the outputs from the next cycle. The destination result goes out as a one-cycle pulse on `dst_valid` with `dst_data`. It has no ready: the register file it feeds cannot stall. A plain software port can load or clear each stored value.

Top module: `mac_unit`

## Requirements
- R1: Synchronous reset clears `acc_hi`, `acc_lo`, `aux_q`, `ovf_flag` and `dst_valid`. `in_ready` is always 1.
- R2: Codes 0 (signed) and 1 (unsigned) form the 64-bit product of the sign- or zero-extended operands. The low product word is added to `acc_lo`. The high product word plus the carry out of that addition is added to `acc_hi`. Results are visible in the cycle after acceptance.
- R3: In codes 0 and 1, overflow is set when old `acc_hi` bit 31 equals product bit 63 and the new `acc_hi` bit 31 differs from it. The same rule applies to both codes.
- R4: Codes 2 (signed) and 3 (unsigned) multiply bits [7:0] of both operands. The extended product is added to `acc_lo`, and `acc_hi` is unchanged.
- R5: Codes 4 (signed) and 5 (unsigned) do the same with bits [15:0].
- R6: Codes 6 (signed) and 7 (unsigned) add both the [15:0]x[15:0] product and the [31:16]x[31:16] product to `acc_lo`. For these codes and for codes 2 to 5, overflow is set when old `acc_lo` bit 31 equals bit 31 of the low-half (or only) product and the new `acc_lo` bit 31 differs from it.
- R7: The overflow flag is sticky. No operation code clears it.
- R8: Codes 8 (signed) and 9 (unsigned) load `aux_q` with the [15:0] product. They pulse `dst_valid` for one cycle with `dst_data` holding the [31:16] product. The accumulator and the flag are unchanged.
- R9: `dst_valid` is high only in the cycle after a code 8 or 9 operation was accepted.
- R10: With `in_valid` low, or with codes 10 to 15, no stored value changes and `dst_valid` stays low.
- R11: When `sw_we` is high, `sw_sel` picks the register loaded from `sw_wdata`: 0 = `acc_hi`, 1 = `acc_lo`, 2 = `aux_q`, 3 = flag. The flag becomes 1 exactly when `sw_wdata` is nonzero. A software write beats a same-cycle operation on the selected register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit accepts an operation (always 1) |
| in_op | input | 4 | Operation code |
| in_reg | input | 32 | Register operand |
| in_imm | input | 32 | Immediate operand |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Software write target |
| sw_wdata | input | 32 | Software write data |
| acc_hi | output | 32 | High accumulator half |
| acc_lo | output | 32 | Low accumulator half |
| aux_q | output | 32 | Auxiliary product register |
| ovf_flag | output | 1 | Sticky overflow flag |
| dst_valid | output | 1 | Destination write enable |
| dst_data | output | 32 | Destination write data |

## Verification
The assertions take two things for granted. First, `in_op` is stable whenever `in_valid` is high. Second, the hold checks on the accumulator and on `aux_q` apply only in cycles where software is not writing the register under check, so they treat `sw_we` as the only other writer. The stimulus drives each operation for exactly one cycle and mixes in idle cycles that carry non-zero operands. It issues software writes alone, except for one deliberate collision that tests the priority of R11. It also uses codes above 9 to exercise the no-effect path.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [3:0] {
    OP_MAC_W_S  = 4'd0,
    OP_MAC_W_U  = 4'd1,
    OP_MAC_B_S  = 4'd2,
    OP_MAC_B_U  = 4'd3,
    OP_MAC_H_S  = 4'd4,
    OP_MAC_H_U  = 4'd5,
    OP_MAC_D_S  = 4'd6,
    OP_MAC_D_U  = 4'd7,
    OP_DMUL_S   = 4'd8,
    OP_DMUL_U   = 4'd9
  } mac_op_t;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_AUX  = 2'd2,
    SEL_FLAG = 2'd3
  } sw_sel_t;

  // even codes are the signed forms
  function automatic logic op_signed(input logic [3:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int W      = 32,
  parameter int BYTE_W = 8
) (
  input  logic                 sgn,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [2*W-1:0]       word_prod,
  output logic [W-1:0]         byte_prod,
  output logic [1:0][W-1:0]    lane_prod
);
  localparam int HW = W / 2;

  logic [2*W-1:0] wa, wb;
  logic [W-1:0]   ba, bb;

  always_comb begin
    wa = {{W{sgn & a[W-1]}}, a};
    wb = {{W{sgn & b[W-1]}}, b};
    word_prod = wa * wb;
  end

  always_comb begin
    ba = {{(W-BYTE_W){sgn & a[BYTE_W-1]}}, a[BYTE_W-1:0]};
    bb = {{(W-BYTE_W){sgn & b[BYTE_W-1]}}, b[BYTE_W-1:0]};
    byte_prod = ba * bb;
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [W-1:0] la, lb;
    always_comb begin
      la = {{(W-HW){sgn & a[i*HW+HW-1]}}, a[i*HW +: HW]};
      lb = {{(W-HW){sgn & b[i*HW+HW-1]}}, b[i*HW +: HW]};
      lane_prod[i] = la * lb;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]          op,
  input  logic [W-1:0]        hi_q,
  input  logic [W-1:0]        lo_q,
  input  logic [2*W-1:0]      word_prod,
  input  logic [W-1:0]        byte_prod,
  input  logic [1:0][W-1:0]   lane_prod,
  output logic [W-1:0]        hi_d,
  output logic [W-1:0]        lo_d,
  output logic                ovf_set,
  output logic                aux_we,
  output logic [W-1:0]        aux_d,
  output logic                dst_we,
  output logic [W-1:0]        dst_d
);
  logic [W:0]   lo_ext;
  logic [W-1:0] prod_hi;
  logic [W-1:0] term;
  logic         narrow;

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    ovf_set = 1'b0;
    aux_we  = 1'b0;
    dst_we  = 1'b0;
    aux_d   = lane_prod[0];
    dst_d   = lane_prod[1];
    lo_ext  = '0;
    prod_hi = word_prod[2*W-1:W];
    term    = lane_prod[0];
    narrow  = 1'b0;
    case (mac_op_t'(op))
      OP_MAC_W_S, OP_MAC_W_U: begin
        lo_ext  = {1'b0, lo_q} + {1'b0, word_prod[W-1:0]};
        lo_d    = lo_ext[W-1:0];
        hi_d    = hi_q + prod_hi + {{(W-1){1'b0}}, lo_ext[W]};
        ovf_set = (hi_q[W-1] == prod_hi[W-1]) && (prod_hi[W-1] != hi_d[W-1]);
      end
      OP_MAC_B_S, OP_MAC_B_U: begin
        term   = byte_prod;
        narrow = 1'b1;
        lo_d   = lo_q + term;
      end
      OP_MAC_H_S, OP_MAC_H_U: begin
        narrow = 1'b1;
        lo_d   = lo_q + term;
      end
      OP_MAC_D_S, OP_MAC_D_U: begin
        narrow = 1'b1;
        lo_d   = lo_q + lane_prod[0] + lane_prod[1];
      end
      OP_DMUL_S, OP_DMUL_U: begin
        aux_we = 1'b1;
        dst_we = 1'b1;
      end
      default: ;
    endcase
    if (narrow)
      ovf_set = (lo_q[W-1] == term[W-1]) && (term[W-1] != lo_d[W-1]);
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int W      = 32,
  parameter int BYTE_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_reg,
  input  logic [W-1:0] in_imm,
  input  logic         sw_we,
  input  logic [1:0]   sw_sel,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic [W-1:0] aux_q,
  output logic         ovf_flag,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);
  logic [2*W-1:0]     word_prod;
  logic [W-1:0]       byte_prod;
  logic [1:0][W-1:0]  lane_prod;
  logic [W-1:0]       hi_d, lo_d, aux_d, dst_d;
  logic               ovf_set, aux_we, dst_we;
  logic               fire;

  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;

  mac_mult #(.W(W), .BYTE_W(BYTE_W)) u_mult (
    .sgn       (op_signed(in_op)),
    .a         (in_reg),
    .b         (in_imm),
    .word_prod (word_prod),
    .byte_prod (byte_prod),
    .lane_prod (lane_prod)
  );

  mac_accum #(.W(W)) u_accum (
    .op        (in_op),
    .hi_q      (acc_hi),
    .lo_q      (acc_lo),
    .word_prod (word_prod),
    .byte_prod (byte_prod),
    .lane_prod (lane_prod),
    .hi_d      (hi_d),
    .lo_d      (lo_d),
    .ovf_set   (ovf_set),
    .aux_we    (aux_we),
    .aux_d     (aux_d),
    .dst_we    (dst_we),
    .dst_d     (dst_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi    <= '0;
      acc_lo    <= '0;
      aux_q     <= '0;
      ovf_flag  <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      dst_valid <= 1'b0;
      if (fire) begin
        acc_hi    <= hi_d;
        acc_lo    <= lo_d;
        dst_valid <= dst_we;
        if (ovf_set) ovf_flag <= 1'b1;
        if (aux_we)  aux_q    <= aux_d;
        if (dst_we)  dst_data <= dst_d;
      end
      if (sw_we) begin
        case (sw_sel_t'(sw_sel))
          SEL_HI:   acc_hi   <= sw_wdata;
          SEL_LO:   acc_lo   <= sw_wdata;
          SEL_AUX:  aux_q    <= sw_wdata;
          SEL_FLAG: ovf_flag <= |sw_wdata;
          default:  ;
        endcase
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(sw_we && sw_sel == 2'd3)) |=> ovf_flag); // R7

  AST_DST_ONLY_DUAL: assert property (@(posedge clk) disable iff (rst)
    dst_valid |-> $past(in_valid && (in_op == 4'd8 || in_op == 4'd9))); // R9

  AST_HI_KEEP_NARROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op >= 4'd2 && in_op <= 4'd7 && !(sw_we && sw_sel == 2'd0))
      |=> $stable(acc_hi)); // R4

  AST_DMUL_ACC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == 4'd8 || in_op == 4'd9) && !sw_we)
      |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(ovf_flag))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !sw_we)
      |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(aux_q) && !dst_valid)); // R10
endmodule

// File: tb/tb_mac_unit.sv
`timescale 1ns/1ps
module tb_mac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_op;
  logic [31:0] in_reg, in_imm;
  logic        sw_we;
  logic [1:0]  sw_sel;
  logic [31:0] sw_wdata;
  logic [31:0] acc_hi, acc_lo, aux_q, dst_data;
  logic        ovf_flag, dst_valid;

  always #4 clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_reg(in_reg), .in_imm(in_imm),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .aux_q(aux_q), .ovf_flag(ovf_flag),
    .dst_valid(dst_valid), .dst_data(dst_data)
  );

  typedef struct {
    logic [31:0] hi, lo, aux, dd;
    logic        fl, dv;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] m_hi = 0, m_lo = 0, m_aux = 0;
  logic        m_fl = 0;

  function automatic logic [31:0] ext(input logic [31:0] v, input int w, input logic s);
    logic [31:0] r;
    r = v & ((32'h1 << w) - 1);
    if (s && v[w-1]) r = r | ~((32'h1 << w) - 1);
    return r;
  endfunction

  task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic swe, input logic [1:0] ssel,
                      input logic [31:0] sd, input string req);
    exp_t e;
    logic [63:0] p;
    logic [32:0] l33;
    logic [31:0] t0, t1, nl, nh;
    logic s;
    @(negedge clk);
    in_valid = v; in_op = op; in_reg = a; in_imm = b;
    sw_we = swe; sw_sel = ssel; sw_wdata = sd;
    @(posedge clk);
    #1;
    s = ~op[0];
    e.dv = 1'b0;
    e.dd = 32'h0;
    if (v) begin
      t0 = ext(a, 16, s) * ext(b, 16, s);
      t1 = ext(a >> 16, 16, s) * ext(b >> 16, 16, s);
      if (op <= 4'd1) begin
        if (s) p = 64'(longint'($signed(a)) * longint'($signed(b)));
        else   p = {32'h0, a} * {32'h0, b};
        l33 = {1'b0, m_lo} + {1'b0, p[31:0]};
        nh  = m_hi + p[63:32] + {31'h0, l33[32]};
        if (m_hi[31] == p[63] && p[63] != nh[31]) m_fl = 1'b1;
        m_hi = nh;
        m_lo = l33[31:0];
      end else if (op <= 4'd7) begin
        if (op <= 4'd3) t0 = ext(a, 8, s) * ext(b, 8, s);
        nl = m_lo + t0 + ((op >= 4'd6) ? t1 : 32'h0);
        if (m_lo[31] == t0[31] && t0[31] != nl[31]) m_fl = 1'b1;
        m_lo = nl;
      end else if (op <= 4'd9) begin
        m_aux = t0;
        e.dv = 1'b1;
        e.dd = t1;
      end
    end
    if (swe) begin
      case (ssel)
        2'd0: m_hi  = sd;
        2'd1: m_lo  = sd;
        2'd2: m_aux = sd;
        default: m_fl = (sd != 0);
      endcase
    end
    e.hi = m_hi; e.lo = m_lo; e.aux = m_aux; e.fl = m_fl; e.req = req;
    sb.push_back(e);
  endtask

  task automatic op_go(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    step(1'b1, op, a, b, 1'b0, 2'd0, 32'h0, req);
  endtask

  task automatic sw_go(input logic [1:0] sel, input logic [31:0] d, input string req);
    step(1'b0, 4'd0, 32'h0, 32'h0, 1'b1, sel, d, req);
  endtask

  // monitor: compares design outputs with the scoreboard head
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (acc_hi !== e.hi || acc_lo !== e.lo || aux_q !== e.aux || ovf_flag !== e.fl ||
          dst_valid !== e.dv || (e.dv && dst_data !== e.dd)) begin
        n_bad++;
        $display("FAIL %s: got hi=%h lo=%h aux=%h fl=%b dv=%b dd=%h exp hi=%h lo=%h aux=%h fl=%b dv=%b dd=%h",
                 e.req, acc_hi, acc_lo, aux_q, ovf_flag, dst_valid, dst_data,
                 e.hi, e.lo, e.aux, e.fl, e.dv, e.dd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_op = 4'd0; in_reg = 32'h1234; in_imm = 32'h55;
    sw_we = 1'b0; sw_sel = 2'd0; sw_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    n_chk++;
    if (acc_hi !== 0 || acc_lo !== 0 || aux_q !== 0 || ovf_flag !== 0 || dst_valid !== 0 || in_ready !== 1) begin
      n_bad++;
      $display("FAIL R1: got hi=%h lo=%h aux=%h fl=%b dv=%b rdy=%b exp all zero, ready 1",
               acc_hi, acc_lo, aux_q, ovf_flag, dst_valid, in_ready);
    end
    // R2 word signed with carry from low into high half
    sw_go(2'd1, 32'hFFFF_FFF0, "R11 load lo");
    op_go(4'd0, 32'h0000_0010, 32'h0000_0001, "R2 word signed carry");
    op_go(4'd0, 32'hFFFF_FFFD, 32'h0000_0007, "R2 word signed negative");
    op_go(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 word unsigned");
    // R3 word overflow
    sw_go(2'd0, 32'h7FFF_FFFF, "R11 load hi");
    sw_go(2'd1, 32'h0, "R11 load lo");
    op_go(4'd0, 32'h0001_0000, 32'h0001_0000, "R3 word overflow");
    op_go(4'd0, 32'h2, 32'h3, "R7 flag stays set");
    sw_go(2'd3, 32'h0, "R11 clear flag");
    sw_go(2'd0, 32'h7FFF_FFFF, "R11 load hi");
    op_go(4'd1, 32'h8000_0000, 32'h2, "R3 unsigned same sign rule");
    sw_go(2'd3, 32'h0, "R11 clear flag");
    // R4 byte modes
    op_go(4'd2, 32'hABCD_EF80, 32'h1234_567F, "R4 byte signed");
    op_go(4'd3, 32'hABCD_EF80, 32'h1234_56FF, "R4 byte unsigned");
    // R5 half modes
    op_go(4'd4, 32'h1111_8000, 32'h2222_7FFF, "R5 half signed");
    op_go(4'd5, 32'h1111_FFFF, 32'h2222_FFFF, "R5 half unsigned");
    // R6 dual accumulate and narrow overflow
    op_go(4'd6, 32'hFFFE_0003, 32'h0005_FFFC, "R6 dual signed");
    op_go(4'd7, 32'h0102_0304, 32'hFFFF_0010, "R6 dual unsigned");
    sw_go(2'd1, 32'h7FFF_FFF0, "R11 load lo");
    op_go(4'd4, 32'h0000_0100, 32'h0000_0100, "R6 narrow overflow");
    op_go(4'd6, 32'h0001_0001, 32'h0001_0001, "R7 flag sticky after dual");
    // R8 dual multiply
    op_go(4'd8, 32'hFFFF_0003, 32'h0004_FFFE, "R8 dual mul signed");
    op_go(4'd9, 32'hFFFF_0003, 32'h0004_FFFE, "R8 dual mul unsigned");
    op_go(4'd2, 32'h5, 32'h6, "R9 no dst pulse");
    // R10 idle and illegal codes
    step(1'b0, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0, "R10 idle");
    op_go(4'd10, 32'h1234_5678, 32'h9ABC_DEF0, "R10 code 10");
    op_go(4'd15, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R10 code 15");
    // R11 software writes
    sw_go(2'd2, 32'hCAFE_F00D, "R11 load aux");
    sw_go(2'd3, 32'h0000_0100, "R11 flag set from nonzero");
    sw_go(2'd3, 32'h0, "R11 flag clear");
    step(1'b1, 4'd0, 32'h3, 32'h4, 1'b1, 2'd1, 32'h0BAD_0BAD, "R11 priority over op");
    step(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, "R10 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule